// File: doc/BRIEF.md
# Caption Data Line Inserter

This block builds the closed-caption data line for standard-definition video as a stream of digital luma codes and splices it into the picture stream. On every other line it forwards the incoming luma samples unchanged, one clock later. On the two caption lines it discards the incoming pixels and drives its own waveform instead. With captioning enabled, these are line 21 of the odd field and line 284 of the even field. The waveform is a seven-cycle sinusoidal clock run-in, two bit periods at blanking, a logic-1 start bit and sixteen data bits.

Bit timing comes from a fractional phase accumulator running at the sample clock. The run-in sinusoid and the data bits share one period, the bit period. Each caption line takes its byte pair from its own pair of input registers. A single-depth buffer captures the pair during the line before the caption line, so the bytes go out in the same field. The block adds an odd-parity bit to each 7-bit character. Software that writes nothing keeps the last captured pair on air. Writing zero to both bytes gives a null pair.

Top module: `cc_line_inserter`

## Requirements
- R1: `cc_active` is high one clock after a sample for which `cc_en` is 1 and either `line_num` is 21 with `field_odd` 1 or `line_num` is 284 with `field_odd` 0. It is low one clock after every other sample.
- R2: On a caption line, sample offset n = `pix_cnt` − 284 (n ≥ 0) has phase P = n·INC, where INC = round(503500·2^24 / 27000000) = 312864. Its bit index is P>>24. For bit indices 0 to 6 the output is 16 + round(110·(1 − cos(2π·k/16))/2), where k = P[23:20], so each bit period holds exactly one run-in cycle.
- R3: On a caption line, the output is blanking code 16 for `pix_cnt` < 284, for bit indices 7 and 8, and for bit index 26 onward. Bit index 9 is the start bit and is code 126.
- R4: Bit indices 10 to 25 carry the frame LSB first: byte 0 bits D0..D6 and then its parity bit, followed by byte 1 in the same layout. A 1 is code 126 and a 0 is code 16.
- R5: Each parity bit makes its 8-bit character odd. A null pair (both bytes zero) is sent as 0x80 per character.
- R6: The caption buffer loads `norm_byte0`/`norm_byte1` (bits 6:0) on every sample of line 20 with `field_odd` 1. It loads `ext_byte0`/`ext_byte1` on every sample of line 283 with `field_odd` 0. Loading does not depend on `cc_en`. At all other times the buffer holds, so register writes during a caption line have no effect, and a caption line with no preceding load line resends the last captured pair.
- R7: On every sample that is not caption-line (R1), `pix_out` equals that sample's `pix_in`, one clock later. On caption lines `pix_in` has no effect on `pix_out`.
- R8: While `rst_n` is low, `pix_out` is 0 and `cc_active` is 0, and the buffer is cleared to the null pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | 10 | Current line number within the frame |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| pix_cnt | input | 11 | Sample index within the line, starting at 0 |
| cc_en | input | 1 | Caption insertion enable |
| norm_byte0 | input | 8 | First character for line 21 (bits 6:0 used) |
| norm_byte1 | input | 8 | Second character for line 21 (bits 6:0 used) |
| ext_byte0 | input | 8 | First character for line 284 (bits 6:0 used) |
| ext_byte1 | input | 8 | Second character for line 284 (bits 6:0 used) |
| pix_in | input | 8 | Incoming luma sample |
| pix_out | output | 8 | Luma sample out, one clock after input |
| cc_active | output | 1 | High while caption waveform replaces the picture |

## Verification
The in-design checks assume that `pix_cnt` rises by exactly one per clock across a line, starting from 0. They also assume that `line_num` and `field_odd` change only where `pix_cnt` returns to 0. The bit timer arms itself on the sample just before offset 284 and then counts freely, so a skipped or repeated sample count would break the bit-index step check. The stimulus drives whole 1716-sample lines with a running counter. It changes the line number and field only between lines, and alters the byte registers only at fixed points inside a line. The scenarios cover load lines, caption lines, wrong-field lines and disabled lines.

// File: rtl/cc_pkg.sv
package cc_pkg;

    // bit-slot layout of a caption line, counted in bit periods from run-in start
    localparam int IDX_W      = 5;
    localparam int RUNIN_BITS = 7;
    localparam int START_IDX  = 9;
    localparam int DATA_IDX0  = 10;
    localparam int DATA_BITS  = 16;
    localparam int END_IDX    = DATA_IDX0 + DATA_BITS;
    localparam int CHAR_BITS  = 7;
    localparam int LUT_AW     = 4;

    // raised-cosine weight, 0..256, for one run-in cycle split into 16 steps
    function automatic logic [8:0] runin_weight(input logic [LUT_AW-1:0] step);
        logic [8:0] w;
        logic [LUT_AW-1:0] m;
        m = step[LUT_AW-1] ? LUT_AW'(5'd16 - {1'b0, step}) : step;
        if (step == 4'd8) begin
            w = 9'd256;
        end else begin
            case (m[2:0])
                3'd0:    w = 9'd0;
                3'd1:    w = 9'd10;
                3'd2:    w = 9'd37;
                3'd3:    w = 9'd79;
                3'd4:    w = 9'd128;
                3'd5:    w = 9'd177;
                3'd6:    w = 9'd219;
                default: w = 9'd246;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer
    import cc_pkg::*;
#(
    parameter int PIX_W       = 11,
    parameter int PHASE_W     = 24,
    parameter int SAMPLE_HZ   = 27000000,
    parameter int BIT_RATE_HZ = 503500,
    parameter int START_PIX   = 284
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_line,
    input  logic [PIX_W-1:0]     pix_cnt,
    output logic                 run,
    output logic [IDX_W-1:0]     bit_idx,
    output logic [LUT_AW-1:0]    step
);

    localparam logic [63:0] INC_WIDE =
        ((64'(BIT_RATE_HZ) << PHASE_W) + 64'(SAMPLE_HZ / 2)) / 64'(SAMPLE_HZ);
    localparam logic [PHASE_W-1:0] INC     = INC_WIDE[PHASE_W-1:0];
    localparam logic [PIX_W-1:0]   ARM_PIX = PIX_W'(START_PIX - 1);
    localparam logic [IDX_W-1:0]   LAST    = IDX_W'(END_IDX - 1);

    typedef struct packed {
        logic               run;
        logic [IDX_W-1:0]   idx;
        logic [PHASE_W-1:0] acc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [PHASE_W:0] sum;

    always_comb begin
        tmr_d = tmr_q;
        sum   = {1'b0, tmr_q.acc} + {1'b0, INC};
        if (!cap_line) begin
            tmr_d.run = 1'b0;
        end else if (pix_cnt == ARM_PIX) begin
            tmr_d.run = 1'b1;
            tmr_d.idx = '0;
            tmr_d.acc = '0;
        end else if (tmr_q.run) begin
            tmr_d.acc = sum[PHASE_W-1:0];
            if (sum[PHASE_W]) begin
                tmr_d.idx = tmr_q.idx + 1'b1;
                if (tmr_q.idx == LAST) begin
                    tmr_d.run = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign run     = tmr_q.run;
    assign bit_idx = tmr_q.idx;
    assign step    = tmr_q.acc[PHASE_W-1 -: LUT_AW];

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bit_idx < IDX_W'(END_IDX)));                                       // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run) |-> (bit_idx == $past(bit_idx) || bit_idx == $past(bit_idx) + 1'b1)); // R2
    AST_ARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap_line) && $past(pix_cnt) == ARM_PIX)
            |-> (run && bit_idx == '0 && step == '0));                              // R2

endmodule

// File: rtl/cc_pair_buffer.sv
module cc_pair_buffer
    import cc_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int NORM_LINE = 21,
    parameter int EXT_LINE  = 284
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINE_W-1:0]    line_num,
    input  logic                 field_odd,
    input  logic [7:0]           norm_byte0,
    input  logic [7:0]           norm_byte1,
    input  logic [7:0]           ext_byte0,
    input  logic [7:0]           ext_byte1,
    output logic [DATA_BITS-1:0] frame
);

    localparam int PAIR_W = 2 * CHAR_BITS;
    localparam logic [LINE_W-1:0] NORM_PREP = LINE_W'(NORM_LINE - 1);
    localparam logic [LINE_W-1:0] EXT_PREP  = LINE_W'(EXT_LINE - 1);

    typedef struct packed {
        logic [PAIR_W-1:0] chars;
    } buf_t;

    buf_t buf_d, buf_q;
    logic load_norm, load_ext;

    always_comb begin
        buf_d     = buf_q;
        load_norm = (line_num == NORM_PREP) && field_odd;
        load_ext  = (line_num == EXT_PREP) && !field_odd;
        if (load_norm) begin
            buf_d.chars = {norm_byte1[CHAR_BITS-1:0], norm_byte0[CHAR_BITS-1:0]};
        end else if (load_ext) begin
            buf_d.chars = {ext_byte1[CHAR_BITS-1:0], ext_byte0[CHAR_BITS-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_char
        assign frame[8*g +: CHAR_BITS] = buf_q.chars[CHAR_BITS*g +: CHAR_BITS];
        assign frame[8*g + CHAR_BITS]  = ~^buf_q.chars[CHAR_BITS*g +: CHAR_BITS];
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_norm) && !$past(load_ext)) |-> $stable(buf_q));      // R6
    AST_CHAR0_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(frame[7:0]) % 2) == 1);                                           // R5
    AST_CHAR1_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(frame[15:8]) % 2) == 1);                                          // R5

endmodule

// File: rtl/cc_level_map.sv
module cc_level_map
    import cc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_LO = 16,
    parameter int LVL_HI = 126
) (
    input  logic                 run,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic [LUT_AW-1:0]    step,
    input  logic [DATA_BITS-1:0] frame,
    output logic [DATA_W-1:0]    code
);

    localparam int SPAN = LVL_HI - LVL_LO;
    localparam logic [DATA_W-1:0] CODE_LO = DATA_W'(LVL_LO);
    localparam logic [DATA_W-1:0] CODE_HI = DATA_W'(LVL_HI);

    int unsigned scaled;
    logic [IDX_W-1:0] data_pos;

    always_comb begin
        scaled   = (32'(SPAN) * 32'(runin_weight(step)) + 32'd128) >> 8;
        data_pos = bit_idx - IDX_W'(DATA_IDX0);
        code     = CODE_LO;
        if (run) begin
            if (bit_idx < IDX_W'(RUNIN_BITS)) begin
                code = CODE_LO + DATA_W'(scaled);
            end else if (bit_idx == IDX_W'(START_IDX)) begin
                code = CODE_HI;
            end else if (bit_idx >= IDX_W'(DATA_IDX0) && bit_idx < IDX_W'(END_IDX)) begin
                code = frame[data_pos[3:0]] ? CODE_HI : CODE_LO;
            end
        end
    end

endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
    import cc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LINE_W      = 10,
    parameter int PIX_W       = 11,
    parameter int PHASE_W     = 24,
    parameter int SAMPLE_HZ   = 27000000,
    parameter int BIT_RATE_HZ = 503500,
    parameter int START_PIX   = 284,
    parameter int NORM_LINE   = 21,
    parameter int EXT_LINE    = 284,
    parameter int LVL_LO      = 16,
    parameter int LVL_HI      = 126
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic              cc_en,
    input  logic [7:0]        norm_byte0,
    input  logic [7:0]        norm_byte1,
    input  logic [7:0]        ext_byte0,
    input  logic [7:0]        ext_byte1,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] pix_out,
    output logic              cc_active
);

    localparam logic [LINE_W-1:0] NORM_L = LINE_W'(NORM_LINE);
    localparam logic [LINE_W-1:0] EXT_L  = LINE_W'(EXT_LINE);

    typedef struct packed {
        logic              act;
        logic [DATA_W-1:0] pix;
    } out_t;

    out_t out_d, out_q;
    logic cap_line;
    logic run;
    logic [IDX_W-1:0] bit_idx;
    logic [LUT_AW-1:0] step;
    logic [DATA_BITS-1:0] frame;
    logic [DATA_W-1:0] cap_code;

    assign cap_line = cc_en && ((line_num == NORM_L && field_odd) ||
                                (line_num == EXT_L && !field_odd));

    cc_bit_timer #(
        .PIX_W(PIX_W), .PHASE_W(PHASE_W), .SAMPLE_HZ(SAMPLE_HZ),
        .BIT_RATE_HZ(BIT_RATE_HZ), .START_PIX(START_PIX)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .cap_line(cap_line), .pix_cnt(pix_cnt),
        .run(run), .bit_idx(bit_idx), .step(step)
    );

    cc_pair_buffer #(
        .LINE_W(LINE_W), .NORM_LINE(NORM_LINE), .EXT_LINE(EXT_LINE)
    ) i_buffer (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_odd(field_odd),
        .norm_byte0(norm_byte0), .norm_byte1(norm_byte1),
        .ext_byte0(ext_byte0), .ext_byte1(ext_byte1), .frame(frame)
    );

    cc_level_map #(
        .DATA_W(DATA_W), .LVL_LO(LVL_LO), .LVL_HI(LVL_HI)
    ) i_level (
        .run(run), .bit_idx(bit_idx), .step(step), .frame(frame), .code(cap_code)
    );

    always_comb begin
        out_d.act = cap_line;
        out_d.pix = cap_line ? cap_code : pix_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pix_out   = out_q.pix;
    assign cc_active = out_q.act;

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cc_en) |-> !cc_active);                                                // R1
    AST_LINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cc_active |-> ($past(line_num) == NORM_L || $past(line_num) == EXT_L));        // R1
    AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cap_line)) |-> (pix_out == $past(pix_in) && !cc_active)); // R7
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_active |-> (pix_out >= DATA_W'(LVL_LO) && pix_out <= DATA_W'(LVL_HI)));      // R4

endmodule

// File: tb/test_cc_line_inserter.sv
module test_cc_line_inserter;

    localparam int LINE_PIX = 1716;
    localparam int START    = 284;
    localparam int LO       = 16;
    localparam int HI       = 126;
    localparam longint INC  = ((longint'(503500) << 24) + 13500000) / 27000000;

    typedef struct {
        logic [7:0] pix;
        logic       act;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] line_num = '0;
    logic       field_odd = 1'b0;
    logic [10:0] pix_cnt = '0;
    logic       cc_en = 1'b0;
    logic [7:0] norm_byte0 = '0, norm_byte1 = '0, ext_byte0 = '0, ext_byte1 = '0;
    logic [7:0] pix_in = '0;
    logic [7:0] pix_out;
    logic       cc_active;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    logic [6:0] m_c0 = '0, m_c1 = '0;

    always #4 clk = ~clk;

    cc_line_inserter i_cc_line_inserter (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_odd(field_odd),
        .pix_cnt(pix_cnt), .cc_en(cc_en), .norm_byte0(norm_byte0), .norm_byte1(norm_byte1),
        .ext_byte0(ext_byte0), .ext_byte1(ext_byte1), .pix_in(pix_in),
        .pix_out(pix_out), .cc_active(cc_active)
    );

    function automatic int sine_code(int k);
        real w;
        w = (1.0 - $cos(2.0 * 3.14159265358979 * k / 16.0)) / 2.0;
        return LO + $rtoi((HI - LO) * w + 0.5);
    endfunction

    function automatic logic frame_bit(int k, logic [6:0] c0, logic [6:0] c1);
        logic [6:0] c;
        int pos;
        c   = (k < 8) ? c0 : c1;
        pos = k % 8;
        if (pos < 7) return c[pos];
        return ~^c;
    endfunction

    // expected caption code and the requirement it exercises
    task automatic cap_expect(input int p, output logic [7:0] code, output string req);
        longint acc;
        int b, k;
        code = 8'(LO);
        req  = "R3";
        if (p >= START) begin
            acc = longint'(p - START) * INC;
            b   = int'(acc >>> 24);
            k   = int'((acc >>> 20) & 15);
            if (b < 7) begin
                code = 8'(sine_code(k)); req = "R2";
            end else if (b == 9) begin
                code = 8'(HI); req = "R3";
            end else if (b >= 10 && b < 26) begin
                code = frame_bit(b - 10, m_c0, m_c1) ? 8'(HI) : 8'(LO);
                req  = (((b - 10) % 8) == 7) ? "R5" : "R4";
            end
        end
    endtask

    task automatic drive_line(input int ln, input logic fo, input logic en,
                              input int mut_pix, input string tag);
        for (int p = 0; p < LINE_PIX; p++) begin
            exp_t e;
            logic cap;
            @(negedge clk);
            if (p == mut_pix) begin
                norm_byte0 = 8'h55; norm_byte1 = 8'h2A;
                ext_byte0  = 8'h66; ext_byte1  = 8'h19;
            end
            line_num  = 10'(ln);
            field_odd = fo;
            cc_en     = en;
            pix_cnt   = 11'(p);
            pix_in    = 8'((p * 7 + ln) & 255);
            cap = en && ((ln == 21 && fo) || (ln == 284 && !fo));
            e.act = cap;
            if (cap) begin
                cap_expect(p, e.pix, e.req);
                e.req = {e.req, "/", tag};
            end else begin
                e.pix = pix_in;
                e.req = {"R7/", tag};
            end
            sb.push_back(e);
            if (ln == 20 && fo) begin
                m_c0 = norm_byte0[6:0]; m_c1 = norm_byte1[6:0];
            end else if (ln == 283 && !fo) begin
                m_c0 = ext_byte0[6:0]; m_c1 = ext_byte1[6:0];
            end
        end
    endtask

    // scoreboard monitor: output registered at the edge after the drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pix_out !== e.pix) begin
                    errors++;
                    $display("FAIL %s pix_out actual=%0d expected=%0d", e.req, pix_out, e.pix);
                end
                checks++;
                if (cc_active !== e.act) begin
                    errors++;
                    $display("FAIL R1 cc_active actual=%0b expected=%0b (%s)", cc_active, e.act, e.req);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        checks++;
        if (pix_out !== 8'd0 || cc_active !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset actual=%0d/%0b expected=0/0", pix_out, cc_active);
        end
        rst_n = 1'b1;

        norm_byte0 = 8'h41; norm_byte1 = 8'h42;
        drive_line(19, 1'b1, 1'b1, -1, "R7");
        drive_line(20, 1'b1, 1'b1, -1, "R6");
        drive_line(21, 1'b1, 1'b1, 700, "R6_write_during_caption");
        drive_line(22, 1'b1, 1'b1, -1, "R7");

        ext_byte0 = 8'h13; ext_byte1 = 8'h7F;
        drive_line(283, 1'b0, 1'b1, -1, "R6");
        drive_line(284, 1'b0, 1'b1, -1, "R1_extended");
        drive_line(285, 1'b0, 1'b1, -1, "R7");

        drive_line(21, 1'b1, 1'b1, -1, "R6_stale_pair");

        norm_byte0 = 8'h00; norm_byte1 = 8'h00;
        drive_line(20, 1'b1, 1'b1, -1, "R5");
        drive_line(21, 1'b1, 1'b1, -1, "R5_null_pair");

        norm_byte0 = 8'h6B; norm_byte1 = 8'h01;
        drive_line(20, 1'b1, 1'b0, -1, "R6_load_when_disabled");
        drive_line(21, 1'b1, 1'b0, -1, "R1_disabled");
        drive_line(21, 1'b0, 1'b1, -1, "R1_wrong_field");
        drive_line(284, 1'b1, 1'b1, -1, "R1_wrong_field");
        drive_line(21, 1'b1, 1'b1, -1, "R4");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule